// File: doc/BRIEF.md
# Interrupt translator register file

This block is the software-visible register file of an interrupt translation unit. It holds the control word, the command queue base, the command queue write and read pointers, a bank of table base registers and a set of fixed identification words. Software reaches it through a single-cycle request port that carries an address, a write flag, 64 bits of data and a width flag. A narrow (32-bit) access touches one half of a 64-bit slot. A wide access touches both halves. Every request gets a response one cycle later, with an error flag for offsets that decode to nothing.

Once software sets the enable bit, the configuration registers freeze. The block also emits a one-cycle pulse so that the command engine and the table walker can capture the queue and table parameters, which the block drives out continuously. The command engine advances the read pointer through a load port. The bus can only read that pointer, and an enable write or a queue base reprogram resets it to zero.

Narrow writes merge into the unaddressed half without disturbing it. The write pointer's retry flag at bit 0 is cleared only when the low half is written. Bits that are read-only in a table base register keep their stored values.

Top module: `itr_regfile`

## Requirements
- R1: The control word (32 bits, at offset 0x000, low half of slot 0) is set-only: a write covering the low half stores old | data[31:0]. Bit 0 is the enable bit and is driven on `unit_enable`.
- R2: A control write that leaves bit 0 set raises `latch_pulse` for exactly the cycle after the request, and in that cycle the read pointer reads zero. This holds even if the enable bit was already set.
- R3: While the enable bit is set, writes to the queue base (0x080) and to every table base register leave them unchanged and complete without error.
- R4: A queue base write that covers the low half (a narrow write at 0x080 or a wide write) clears the read pointer. A narrow write to the high half (0x084) leaves the read pointer unchanged.
- R5: The write pointer (0x088) takes written data, except that bit 0 is forced to 0 when the low half is written. A narrow write at 0x08C stores data[31:0] into bits 63:32 unmasked.
- R6: Table base register i sits at 0x100 + 8*i, and address bit 2 selects the high half. Writable bits take the written 1 or 0, the unaddressed half is kept, and bits set in the read-only mask keep their value. After reset, the masked bits hold mask & {8{byte(i+1)}}.
- R7: Writes to the identity word (0x004), the type register (0x008), the read pointer (0x090) and the identification block (0x180 to 0x1AF) change nothing and return no error.
- R8: `rsp_valid` rises in the cycle after each request. A narrow read returns the addressed half in bits 31:0, with bits 63:32 zero. A wide read returns the whole slot. Identification word w (w = 0..11 at 0x180 + 4*w) reads {ID_SIG, w}, and the identity word reads ID_VALUE.
- R9: An unmapped offset, a non-word-aligned address, or a wide access with address bit 2 set returns `rsp_err` = 1 with zero data and changes no state.
- R10: After reset, control, queue base, write pointer, read pointer and every writable table bit are zero, and all outputs are idle.
- R11: `rd_load` loads `rd_load_val` into the read pointer. If a clear from R2 or R4 happens in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 64 | Write data (bits 31:0 for narrow writes) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data |
| unit_enable | output | 1 | Enable bit of the control word |
| latch_pulse | output | 1 | One-cycle parameter capture strobe |
| qbase_o | output | 64 | Command queue base |
| qwr_o | output | 64 | Command queue write pointer |
| qrd_o | output | 64 | Command queue read pointer |
| tbase_o | output | NUM_TBASE*64 | Table base registers, entry i in bits 64*i+63:64*i |
| rd_load | input | 1 | Read pointer load from the command engine |
| rd_load_val | input | 64 | Read pointer load value |

## Verification
Every result lands on the clock edge that samples the request: the response, the register updates, `latch_pulse` and the read pointer clear. All of them become visible one cycle after the request. The bench therefore drives each request on a falling edge and samples everything on the next falling edge, half a period after the updating edge. A register's new contents are checked by a later read, which again lands one cycle after it is issued. Full address sweeps after reset, after the unmapped and read-only writes, and at the end compare every readable word against an arithmetic model.

// File: rtl/itr_pkg.sv
package itr_pkg;
  localparam int DATA_W      = 64;
  localparam int HALF_W      = 32;
  localparam int CTRL_W      = 32;
  localparam int EN_BIT      = 0;
  localparam int IDX_W       = 3;
  // slot numbers (byte offset / 8)
  localparam int SLOT_CTRLID = 0;
  localparam int SLOT_TYPE   = 1;
  localparam int SLOT_QBASE  = 16;
  localparam int SLOT_QWR    = 17;
  localparam int SLOT_QRD    = 18;
  localparam int SLOT_TBASE  = 32;
  localparam int SLOT_IDENT  = 48;
  localparam int IDENT_SLOTS = 6;
  localparam logic [DATA_W-1:0] RETRY_MASK = 64'h1;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRLID, RG_TYPE, RG_QBASE, RG_QWR, RG_QRD, RG_TBASE, RG_IDENT
  } region_e;

  typedef struct packed {
    region_e          region;
    logic [IDX_W-1:0] idx;
    logic             lo_en;
    logic             hi_en;
    logic             err;
  } dec_t;

  function automatic logic [DATA_W-1:0] lane_mask(input logic lo, input logic hi);
    return {{HALF_W{hi}}, {HALF_W{lo}}};
  endfunction

  function automatic logic [DATA_W-1:0] merge64(input logic [DATA_W-1:0] old_v,
                                                input logic [DATA_W-1:0] new_v,
                                                input logic [DATA_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic [HALF_W-1:0] ident_word(input logic [23:0] sig, input int w);
    return {sig, 8'(w)};
  endfunction

  function automatic logic [DATA_W-1:0] tbase_fixed(input logic [DATA_W-1:0] ro, input int i);
    return ro & {8{8'(i + 1)}};
  endfunction
endpackage

// File: rtl/itr_decode.sv
module itr_decode import itr_pkg::*; #(
  parameter int ADDR_W    = 12,
  parameter int NUM_TBASE = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output dec_t              dec
);
  logic hi;
  logic misalign;
  int   slot;

  always_comb begin
    hi       = addr[2];
    slot     = int'(addr[ADDR_W-1:3]);
    misalign = (addr[1:0] != 2'b00) || (wide && hi);
    dec        = '0;
    dec.lo_en  = wide || !hi;
    dec.hi_en  = wide || hi;
    dec.region = RG_NONE;
    if (slot == SLOT_CTRLID)      dec.region = RG_CTRLID;
    else if (slot == SLOT_TYPE)   dec.region = RG_TYPE;
    else if (slot == SLOT_QBASE)  dec.region = RG_QBASE;
    else if (slot == SLOT_QWR)    dec.region = RG_QWR;
    else if (slot == SLOT_QRD)    dec.region = RG_QRD;
    else if (slot >= SLOT_TBASE && slot < SLOT_TBASE + NUM_TBASE) begin
      dec.region = RG_TBASE;
      dec.idx    = IDX_W'(slot - SLOT_TBASE);
    end else if (slot >= SLOT_IDENT && slot < SLOT_IDENT + IDENT_SLOTS) begin
      dec.region = RG_IDENT;
      dec.idx    = IDX_W'(slot - SLOT_IDENT);
    end
    if (misalign) dec.region = RG_NONE;
    dec.err = (dec.region == RG_NONE);
  end
endmodule

// File: rtl/itr_qregs.sv
module itr_qregs import itr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qbase_we,
  input  logic              qwr_we,
  input  logic [DATA_W-1:0] lanes,
  input  logic [DATA_W-1:0] wd,
  input  logic              rd_clr,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_load_val,
  output logic [DATA_W-1:0] qbase_q,
  output logic [DATA_W-1:0] qwr_q,
  output logic [DATA_W-1:0] qrd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qbase_q <= '0;
      qwr_q   <= '0;
      qrd_q   <= '0;
    end else begin
      if (qbase_we) qbase_q <= merge64(qbase_q, wd, lanes);
      // retry flag only lives in the low lane, so masking the data is lane-safe
      if (qwr_we)   qwr_q   <= merge64(qwr_q, wd & ~RETRY_MASK, lanes);
      if (rd_clr)       qrd_q <= '0;
      else if (rd_load) qrd_q <= rd_load_val;
    end
  end
endmodule

// File: rtl/itr_tbase_bank.sv
module itr_tbase_bank import itr_pkg::*; #(
  parameter int                NUM_TBASE = 8,
  parameter logic [DATA_W-1:0] RO_MASK   = 64'h0700_0000_0000_001F
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           lanes,
  input  logic [DATA_W-1:0]           wd,
  output logic [NUM_TBASE*DATA_W-1:0] tb_flat
);
  localparam logic [DATA_W-1:0] WR_MASK = ~RO_MASK;

  for (genvar i = 0; i < NUM_TBASE; i++) begin : g_entry
    localparam logic [DATA_W-1:0] FIXED = tbase_fixed(RO_MASK, i);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q <= FIXED;
      else if (we && int'(idx) == i)  q <= merge64(q, wd, lanes & WR_MASK);
    end
    assign tb_flat[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/itr_regfile.sv
module itr_regfile import itr_pkg::*; #(
  parameter int                ADDR_W     = 12,
  parameter int                NUM_TBASE  = 8,
  parameter logic [31:0]       ID_VALUE   = 32'h1234_5A01,
  parameter logic [23:0]       ID_SIG     = 24'hC0DE42,
  parameter logic [63:0]       TYPE_VALUE = 64'h0000_0010_0008_0F11,
  parameter logic [63:0]       TB_RO_MASK = 64'h0700_0000_0000_001F
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic                        req_wide,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [63:0]                 req_wdata,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [63:0]                 rsp_rdata,
  output logic                        unit_enable,
  output logic                        latch_pulse,
  output logic [63:0]                 qbase_o,
  output logic [63:0]                 qwr_o,
  output logic [63:0]                 qrd_o,
  output logic [NUM_TBASE*64-1:0]     tbase_o,
  input  logic                        rd_load,
  input  logic [63:0]                 rd_load_val
);
  dec_t              dec;
  logic [DATA_W-1:0] wd, lanes, slot_val, rdata;
  logic [CTRL_W-1:0] ctrl_q, ctrl_next;
  logic              wr, ctrl_wr, latch_next, locked;
  logic              qbase_we, qwr_we, tb_we, rd_clr;
  logic [DATA_W-1:0] tb_sel;

  itr_decode #(.ADDR_W(ADDR_W), .NUM_TBASE(NUM_TBASE)) u_dec (
    .addr(req_addr), .wide(req_wide), .dec(dec)
  );

  // narrow data is replicated into both lanes; the lane mask picks the half
  assign wd     = req_wide ? req_wdata : {2{req_wdata[HALF_W-1:0]}};
  assign lanes  = lane_mask(dec.lo_en, dec.hi_en);
  assign wr     = req_valid && req_write && !dec.err;
  assign locked = ctrl_q[EN_BIT];

  assign ctrl_wr    = wr && dec.region == RG_CTRLID && dec.lo_en;
  assign ctrl_next  = ctrl_q | wd[CTRL_W-1:0];
  assign latch_next = ctrl_wr && ctrl_next[EN_BIT];
  assign qbase_we   = wr && dec.region == RG_QBASE && !locked;
  assign qwr_we     = wr && dec.region == RG_QWR;
  assign tb_we      = wr && dec.region == RG_TBASE && !locked;
  assign rd_clr     = latch_next || (qbase_we && dec.lo_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      latch_pulse <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_next;
      latch_pulse <= latch_next;
    end
  end

  itr_qregs u_q (
    .clk(clk), .rst_n(rst_n), .qbase_we(qbase_we), .qwr_we(qwr_we),
    .lanes(lanes), .wd(wd), .rd_clr(rd_clr), .rd_load(rd_load),
    .rd_load_val(rd_load_val), .qbase_q(qbase_o), .qwr_q(qwr_o), .qrd_q(qrd_o)
  );

  itr_tbase_bank #(.NUM_TBASE(NUM_TBASE), .RO_MASK(TB_RO_MASK)) u_tb (
    .clk(clk), .rst_n(rst_n), .we(tb_we), .idx(dec.idx),
    .lanes(lanes), .wd(wd), .tb_flat(tbase_o)
  );

  always_comb begin
    tb_sel = '0;
    for (int i = 0; i < NUM_TBASE; i++)
      if (int'(dec.idx) == i) tb_sel = tbase_o[i*DATA_W +: DATA_W];
  end

  always_comb begin
    unique case (dec.region)
      RG_CTRLID: slot_val = {ID_VALUE, ctrl_q};
      RG_TYPE:   slot_val = TYPE_VALUE;
      RG_QBASE:  slot_val = qbase_o;
      RG_QWR:    slot_val = qwr_o;
      RG_QRD:    slot_val = qrd_o;
      RG_TBASE:  slot_val = tb_sel;
      RG_IDENT:  slot_val = {ident_word(ID_SIG, 2 * int'(dec.idx) + 1),
                            ident_word(ID_SIG, 2 * int'(dec.idx))};
      default:   slot_val = '0;
    endcase
    if (dec.err)       rdata = '0;
    else if (req_wide) rdata = slot_val;
    else               rdata = {{HALF_W{1'b0}},
                                req_addr[2] ? slot_val[DATA_W-1:HALF_W] : slot_val[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec.err;
      rsp_rdata <= req_valid ? rdata : '0;
    end
  end

  assign unit_enable = ctrl_q[EN_BIT];
endmodule

// File: rtl/itr_regfile_chk.sv
module itr_regfile_chk #(
  parameter int NUM_TBASE = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [31:0]             ctrl_q,
  input logic                    unit_enable,
  input logic                    latch_pulse,
  input logic                    req_valid,
  input logic                    rsp_valid,
  input logic                    rsp_err,
  input logic [63:0]             rsp_rdata,
  input logic [63:0]             qbase_o,
  input logic [63:0]             qwr_o,
  input logic [63:0]             qrd_o,
  input logic [NUM_TBASE*64-1:0] tbase_o
);
  assert_ctrl_set_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ctrl_q) & ~ctrl_q) == 32'h0));

  assert_latch_rd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> (qrd_o == 64'h0 && unit_enable));

  assert_qbase_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_enable && $past(unit_enable)) |-> $stable(qbase_o));

  assert_tbase_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_enable && $past(unit_enable)) |-> $stable(tbase_o));

  assert_retry_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    qwr_o[0] == 1'b0);

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $past(rst_n)) |-> rsp_valid);

  assert_no_stray_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !rsp_valid);

  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 64'h0));
endmodule

bind itr_regfile itr_regfile_chk #(.NUM_TBASE(NUM_TBASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .unit_enable(unit_enable),
  .latch_pulse(latch_pulse), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .qbase_o(qbase_o), .qwr_o(qwr_o),
  .qrd_o(qrd_o), .tbase_o(tbase_o)
);

// File: tb/test_itr_regfile.sv
`timescale 1ns/1ps
module test_itr_regfile;
  localparam int          AW    = 12;
  localparam int          NTB   = 8;
  localparam logic [31:0] IDV   = 32'h1234_5A01;
  localparam logic [23:0] SIG   = 24'hC0DE42;
  localparam logic [63:0] TYPEV = 64'h0000_0010_0008_0F11;
  localparam logic [63:0] RO    = 64'h0700_0000_0000_001F;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_wide = 0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic unit_enable, latch_pulse;
  logic [63:0] qbase_o, qwr_o, qrd_o;
  logic [NTB*64-1:0] tbase_o;
  logic rd_load = 0;
  logic [63:0] rd_load_val = '0;

  always #2.5 clk = ~clk;

  itr_regfile #(.ADDR_W(AW), .NUM_TBASE(NTB), .ID_VALUE(IDV), .ID_SIG(SIG),
                .TYPE_VALUE(TYPEV), .TB_RO_MASK(RO)) i_itr_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .unit_enable(unit_enable), .latch_pulse(latch_pulse), .qbase_o(qbase_o),
    .qwr_o(qwr_o), .qrd_o(qrd_o), .tbase_o(tbase_o), .rd_load(rd_load),
    .rd_load_val(rd_load_val)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl;
  logic [63:0] m_qbase, m_qwr, m_qrd;
  logic [63:0] m_tb [NTB];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] fixed_of(input int i);
    return RO & {8{8'(i + 1)}};
  endfunction

  function automatic logic [64:0] exp_rd(input logic [AW-1:0] a, input logic wide);
    int s; logic hi, bad; logic [63:0] v;
    s = int'(a[AW-1:3]); hi = a[2]; v = '0;
    bad = (a[1:0] != 2'b00) || (wide && hi);
    if (s == 0)                v = {IDV, m_ctrl};
    else if (s == 1)           v = TYPEV;
    else if (s == 16)          v = m_qbase;
    else if (s == 17)          v = m_qwr;
    else if (s == 18)          v = m_qrd;
    else if (s >= 32 && s < 32 + NTB) v = m_tb[s-32];
    else if (s >= 48 && s < 54) v = {SIG, 8'(2*(s-48)+1), SIG, 8'(2*(s-48))};
    else bad = 1;
    if (bad)  return {1'b1, 64'h0};
    if (wide) return {1'b0, v};
    return {1'b0, 32'h0, hi ? v[63:32] : v[31:0]};
  endfunction

  task automatic bus(input logic w, input logic wide, input logic [AW-1:0] a,
                     input logic [63:0] d, input logic ld, input logic [63:0] lv);
    logic [64:0] e; logic el, hi, lo_en, hi_en;
    logic [63:0] wdv, mk;
    int s;
    e = exp_rd(a, wide);
    @(negedge clk);
    req_valid = 1; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
    rd_load = ld; rd_load_val = lv;
    @(negedge clk);
    req_valid = 0; rd_load = 0;
    // model update from the requirements
    el = 0;
    if (ld) m_qrd = lv;
    if (w && !e[64]) begin
      hi = a[2]; lo_en = wide || !hi; hi_en = wide || hi;
      wdv = wide ? d : {d[31:0], d[31:0]};
      mk = {{32{hi_en}}, {32{lo_en}}};
      s = int'(a[AW-1:3]);
      if (s == 0 && lo_en) begin
        m_ctrl = m_ctrl | wdv[31:0];
        el = m_ctrl[0];
        if (el) m_qrd = '0;
      end else if (s == 16 && !m_ctrl[0]) begin
        m_qbase = (m_qbase & ~mk) | (wdv & mk);
        if (lo_en) m_qrd = '0;
      end else if (s == 17) begin
        m_qwr = (m_qwr & ~mk) | (wdv & ~64'h1 & mk);
      end else if (s >= 32 && s < 32 + NTB && !m_ctrl[0]) begin
        m_tb[s-32] = (m_tb[s-32] & ~(mk & ~RO)) | (wdv & mk & ~RO);
      end
    end
    check(rsp_valid == 1'b1, "R8 rsp_valid", 64'(rsp_valid), 64'h1);
    check(rsp_err == e[64], $sformatf("R9 rsp_err @%h", a), 64'(rsp_err), 64'(e[64]));
    if (!w) check(rsp_rdata == e[63:0], $sformatf("R8 rdata @%h wide=%0d", a, wide), rsp_rdata, e[63:0]);
    check(latch_pulse == el, "R2 latch_pulse", 64'(latch_pulse), 64'(el));
    check(qrd_o == m_qrd, "R11 qrd_o", qrd_o, m_qrd);
    check(unit_enable == m_ctrl[0], "R1 unit_enable", 64'(unit_enable), 64'(m_ctrl[0]));
  endtask

  task automatic rd(input logic wide, input logic [AW-1:0] a);
    bus(0, wide, a, 64'h0, 0, 64'h0);
  endtask
  task automatic wr(input logic wide, input logic [AW-1:0] a, input logic [63:0] d);
    bus(1, wide, a, d, 0, 64'h0);
  endtask

  task automatic sweep();
    for (int a = 0; a < 4096; a += 4) rd(0, AW'(a));
    for (int a = 0; a < 4096; a += 8) rd(1, AW'(a));
    rd(1, 12'h104); rd(1, 12'h00C); rd(0, 12'h102);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ctrl = '0; m_qbase = '0; m_qwr = '0; m_qrd = '0;
    for (int i = 0; i < NTB; i++) m_tb[i] = fixed_of(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state at the ports
    check(unit_enable == 0 && latch_pulse == 0 && rsp_valid == 0, "R10 idle outputs",
          {61'h0, unit_enable, latch_pulse, rsp_valid}, 64'h0);
    check(qbase_o == 0 && qwr_o == 0 && qrd_o == 0, "R10 queue regs zero", qbase_o | qwr_o | qrd_o, 64'h0);
    for (int i = 0; i < NTB; i++)
      check(tbase_o[i*64 +: 64] == fixed_of(i), "R10 R6 table reset", tbase_o[i*64 +: 64], fixed_of(i));
    sweep();

    // R6 table base sweep: every entry, every half, several patterns
    for (int i = 0; i < NTB; i++) begin
      for (int h = 0; h < 2; h++) begin
        for (int p = 0; p < 3; p++) begin
          logic [63:0] pat;
          pat = (p == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : (p == 1) ? 64'h0 : (64'hA5A5_5A5A_C3C3_3C3C ^ 64'(i*77 + h));
          wr(0, AW'(12'h100 + 8*i + 4*h), pat);
          rd(0, AW'(12'h100 + 8*i)); rd(0, AW'(12'h104 + 8*i));
        end
      end
      wr(1, AW'(12'h100 + 8*i), 64'hFFFF_0000_1234_FFFF ^ 64'(i));
      rd(1, AW'(12'h100 + 8*i));
    end

    // R4 R11 queue base and read pointer clearing
    bus(0, 0, 12'h000, 64'h0, 1, 64'h55);
    wr(0, 12'h084, 64'hDEAD_BEEF);
    check(qrd_o == 64'h55, "R4 high half keeps rd ptr", qrd_o, 64'h55);
    wr(0, 12'h080, 64'h0000_1000);
    check(qrd_o == 64'h0, "R4 low half clears rd ptr", qrd_o, 64'h0);
    bus(0, 0, 12'h000, 64'h0, 1, 64'h99);
    wr(1, 12'h080, 64'h0123_4567_89AB_CDE0);
    rd(1, 12'h080); rd(0, 12'h084);

    // R5 write pointer retry bit
    wr(1, 12'h088, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1, 12'h088);
    wr(1, 12'h088, 64'h0);
    wr(0, 12'h08C, 64'hFFFF_FFFF);
    check(qwr_o == 64'hFFFF_FFFF_0000_0000, "R5 high half unmasked", qwr_o, 64'hFFFF_FFFF_0000_0000);
    wr(0, 12'h088, 64'hFFFF_FFFF);
    check(qwr_o == 64'hFFFF_FFFF_FFFF_FFFE, "R5 low half drops retry", qwr_o, 64'hFFFF_FFFF_FFFF_FFFE);

    // R7 read-only writes, R9 unmapped writes
    bus(0, 0, 12'h000, 64'h0, 1, 64'h33);
    wr(0, 12'h004, 64'hFFFF_FFFF); wr(1, 12'h008, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(0, 12'h00C, 64'h0); wr(1, 12'h090, 64'h0); wr(0, 12'h094, 64'hFFFF_FFFF);
    for (int w = 0; w < 12; w++) wr(0, AW'(12'h180 + 4*w), 64'h0);
    check(qrd_o == 64'h33, "R7 rd ptr write ignored", qrd_o, 64'h33);
    wr(0, 12'h040, 64'hFFFF_FFFF); wr(1, 12'h0A0, 64'h1); wr(0, 12'h200, 64'h1);
    wr(0, 12'h102, 64'hFFFF_FFFF); wr(1, 12'h104, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(0, 12'h1B0, 64'h1);
    sweep();

    // R1 R2 control: set-only, pulse, same-cycle load loses (R11)
    wr(0, 12'h000, 64'h6);
    check(unit_enable == 0, "R1 enable stays clear", 64'(unit_enable), 64'h0);
    wr(0, 12'h004, 64'h1);
    bus(1, 0, 12'h000, 64'h1, 1, 64'h77);
    check(qrd_o == 0, "R2 R11 clear wins over load", qrd_o, 64'h0);
    rd(0, 12'h000);
    wr(0, 12'h000, 64'h0);
    rd(0, 12'h000);
    bus(0, 0, 12'h000, 64'h0, 1, 64'h44);

    // R3 lock of queue base and table bases
    wr(1, 12'h080, 64'hFFFF_FFFF_FFFF_FFFF); wr(0, 12'h080, 64'h0); wr(0, 12'h084, 64'h0);
    check(qrd_o == 64'h44, "R3 locked base keeps rd ptr", qrd_o, 64'h44);
    for (int i = 0; i < NTB; i++) begin
      wr(1, AW'(12'h100 + 8*i), 64'h0);
      wr(0, AW'(12'h104 + 8*i), 64'hFFFF_FFFF);
    end
    check(qbase_o == m_qbase, "R3 qbase frozen", qbase_o, m_qbase);
    for (int i = 0; i < NTB; i++)
      check(tbase_o[i*64 +: 64] == m_tb[i], "R3 table frozen", tbase_o[i*64 +: 64], m_tb[i]);
    wr(1, 12'h088, 64'h0000_0000_0000_0041);
    check(qwr_o == 64'h40, "R5 write pointer not locked", qwr_o, 64'h40);
    sweep();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule